// File: doc/BRIEF.md
# GPIO Port with Peripheral Pin Muxing

This block is an eight-bit bidirectional I/O port. Software reaches it over a simple register bus. The bus gives it a data latch and a direction register. For each pad, the block drives an output value, an output enable and an open-drain flag, and it takes in the level seen on the pad. Two peripheral enables take pins away from software control. The serial-peripheral enable hands the upper four pins to the SPI block. The USB enable hands pins 2 and 3 to the USB data lines. When USB is off, those two pins become pull-low-only outputs, and pin 3 can raise a falling-edge interrupt.

Pad inputs pass through a two-flop synchronizer before anything uses them. A read of the data register returns, for each bit, either the latch or the synchronized pad level. The direction bit makes that choice, and it makes it even for a pin that a peripheral currently owns. Because the latch can be written while a pin is still an input, software can preload the output level before it turns the driver on.

Top module: `gpio_mux_port`

## Requirements
- R1: After reset, the direction register and the data latch are zero, every `pin_oe` bit is 0 and `irq_req` is 0.
- R2: The direction register is at address 0x09. Bits 7..2 are read/write. Bits 1 and 0 always read 0, and writes to them are dropped. A direction bit of 1 means output and 0 means input.
- R3: The data latch is at address 0x01. A write to it always updates the latch, whatever the direction bits are.
- R4: A pin that no peripheral owns drives `pin_oe` equal to its direction bit and `pin_out` equal to its latch bit, with `pin_od` at 0. A latch write therefore does not enable a pin whose direction bit is 0.
- R5: A read of address 0x01 returns, for each bit, the latch when the direction bit is 1 and the synchronized pad level when it is 0. This holds even for peripheral-owned pins. A pad change is visible to the read after two rising clock edges.
- R6: While `spi_en` is 1, pins 4..7 take `pin_oe` and `pin_out` from `spi_oe` and `spi_out`. Bit k of those inputs goes to pin 4+k. `pin_od` is 0 on these pins, and the direction register has no effect on their drive.
- R7: While `usb_en` is 1, pin 2 takes `usb_oe[0]`/`usb_out[0]` and pin 3 takes `usb_oe[1]`/`usb_out[1]`, with `pin_od` 0.
- R8: While `usb_en` is 0, pins 2 and 3 have `pin_od` 1 and `pin_out` 0. Each of them has `pin_oe` 1 only when its direction bit is 1 and its latch bit is 0.
- R9: While `ext_irq_en` is 1 and `usb_en` is 0, a high-to-low change on pad 3 sets `irq_req` on the third rising edge after the change. A setting edge wins over a simultaneous `irq_ack`.
- R10: `irq_req` stays set until `irq_ack` is sampled high. It is forced to 0 while `ext_irq_en` is 0 or `usb_en` is 1, and a rising edge on pad 3 never sets it.
- R11: Writes to any address other than 0x01 and 0x09 change nothing, and reads of such addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pin_in | input | 8 | Raw pad levels |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |
| pin_od | output | 8 | Pad open-drain flags |
| spi_en | input | 1 | SPI owns pins 4..7 |
| spi_out | input | 4 | SPI output values for pins 4..7 |
| spi_oe | input | 4 | SPI output enables for pins 4..7 |
| usb_en | input | 1 | USB owns pins 2 and 3 |
| usb_out | input | 2 | USB line values for pins 2 and 3 |
| usb_oe | input | 2 | USB line enables for pins 2 and 3 |
| ext_irq_en | input | 1 | Interrupt enable for pin 3 |
| irq_ack | input | 1 | Clears a pending interrupt |
| irq_req | output | 1 | Pending pin-3 interrupt |

## Verification
The pad outputs depend combinationally on the registers. A register write made at one falling edge is therefore checked on the pads at the next falling edge, after the single rising edge that loads it. Bus reads are combinational and are sampled 1 ns after the address is set. A pad change reaches the read path after two rising edges, and the bench waits exactly two cycles before it reads. `irq_req` is checked to be 0 after the second edge and 1 after the third edge, so an extra or a missing stage shows up as a failure.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;
    localparam int unsigned PORT_W = 8;
    localparam int unsigned ADDR_W = 8;
    localparam int unsigned SPI_W  = 4;
    localparam int unsigned USB_W  = 2;

    typedef logic [PORT_W-1:0] port_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        port_t latch;
        port_t dir;
    } regs_t;

    typedef struct packed {
        port_t stage1;
        port_t stage2;
        logic  prev_irq_pin;
        logic  pending;
    } sync_t;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_mux_pkg::*;
#(
    parameter addr_t DATA_ADDR = 8'h01,
    parameter addr_t DIR_ADDR  = 8'h09,
    parameter port_t DIR_MASK  = 8'hFC
) (
    input  logic  clk,
    input  logic  rst_n,
    input  addr_t bus_addr,
    input  logic  bus_wr,
    input  port_t bus_wdata,
    input  port_t pin_sync,
    output port_t bus_rdata,
    output port_t latch,
    output port_t dir
);
    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (bus_wr && bus_addr == DATA_ADDR) regs_d.latch = bus_wdata;
        if (bus_wr && bus_addr == DIR_ADDR)  regs_d.dir   = bus_wdata & DIR_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == DATA_ADDR)
            bus_rdata = (regs_q.dir & regs_q.latch) | (~regs_q.dir & pin_sync);
        else if (bus_addr == DIR_ADDR)
            bus_rdata = regs_q.dir;
    end

    assign latch = regs_q.latch;
    assign dir   = regs_q.dir;

    // R2
    dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == DIR_ADDR) |=> (dir == ($past(bus_wdata) & DIR_MASK)));
    // R3
    latch_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == DATA_ADDR) |=> (latch == $past(bus_wdata)));
    // R11
    regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && (bus_addr == DATA_ADDR || bus_addr == DIR_ADDR))
        |=> ($stable(latch) && $stable(dir)));
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync
    import gpio_mux_pkg::*;
#(
    parameter int unsigned IRQ_PIN = 3
) (
    input  logic  clk,
    input  logic  rst_n,
    input  port_t pin_in,
    input  logic  ext_irq_en,
    input  logic  usb_en,
    input  logic  irq_ack,
    output port_t pin_sync,
    output logic  irq_req
);
    sync_t sync_d, sync_q;
    logic  qualified;
    logic  fall_seen;

    always_comb begin
        qualified = ext_irq_en && !usb_en;
        fall_seen = sync_q.prev_irq_pin && !sync_q.stage2[IRQ_PIN];
        sync_d = sync_q;
        sync_d.stage1       = pin_in;
        sync_d.stage2       = sync_q.stage1;
        sync_d.prev_irq_pin = sync_q.stage2[IRQ_PIN];
        if (!qualified)     sync_d.pending = 1'b0;
        else if (fall_seen) sync_d.pending = 1'b1;
        else if (irq_ack)   sync_d.pending = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign pin_sync = sync_q.stage2;
    assign irq_req  = sync_q.pending;

    // R9
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_irq_en && !usb_en && sync_q.prev_irq_pin && !pin_sync[IRQ_PIN]) |=> irq_req);
    // R10
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ext_irq_en && !usb_en) |=> !irq_req);
    // R10
    irq_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !(sync_q.prev_irq_pin && !pin_sync[IRQ_PIN])) |=> !irq_req);
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux
    import gpio_mux_pkg::*;
#(
    parameter int unsigned SPI_LSB = 4,
    parameter int unsigned USB_LSB = 2
) (
    input  port_t            latch,
    input  port_t            dir,
    input  logic             spi_en,
    input  logic [SPI_W-1:0] spi_out,
    input  logic [SPI_W-1:0] spi_oe,
    input  logic             usb_en,
    input  logic [USB_W-1:0] usb_out,
    input  logic [USB_W-1:0] usb_oe,
    output port_t            pin_out,
    output port_t            pin_oe,
    output port_t            pin_od
);
    for (genvar i = 0; i < PORT_W; i++) begin : g_pin
        if (i >= SPI_LSB && i < SPI_LSB + SPI_W) begin : g_spi
            assign pin_out[i] = spi_en ? spi_out[i-SPI_LSB] : latch[i];
            assign pin_oe[i]  = spi_en ? spi_oe[i-SPI_LSB]  : dir[i];
            assign pin_od[i]  = 1'b0;
        end else if (i >= USB_LSB && i < USB_LSB + USB_W) begin : g_usb
            assign pin_out[i] = usb_en ? usb_out[i-USB_LSB] : 1'b0;
            assign pin_oe[i]  = usb_en ? usb_oe[i-USB_LSB]  : (dir[i] && !latch[i]);
            assign pin_od[i]  = !usb_en;
            always_comb begin
                // R8
                od_low_only_chk: assert (!(pin_od[i] && pin_out[i]));
            end
        end else begin : g_plain
            assign pin_out[i] = latch[i];
            assign pin_oe[i]  = dir[i];
            assign pin_od[i]  = 1'b0;
        end
    end
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
    import gpio_mux_pkg::*;
#(
    parameter addr_t       DATA_ADDR = 8'h01,
    parameter addr_t       DIR_ADDR  = 8'h09,
    parameter port_t       DIR_MASK  = 8'hFC,
    parameter int unsigned SPI_LSB   = 4,
    parameter int unsigned USB_LSB   = 2,
    parameter int unsigned IRQ_PIN   = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] bus_addr,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic [7:0] pin_in,
    output logic [7:0] pin_out,
    output logic [7:0] pin_oe,
    output logic [7:0] pin_od,
    input  logic       spi_en,
    input  logic [3:0] spi_out,
    input  logic [3:0] spi_oe,
    input  logic       usb_en,
    input  logic [1:0] usb_out,
    input  logic [1:0] usb_oe,
    input  logic       ext_irq_en,
    input  logic       irq_ack,
    output logic       irq_req
);
    port_t pin_sync;
    port_t latch;
    port_t dir;

    gpio_sync #(.IRQ_PIN(IRQ_PIN)) i_sync (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .ext_irq_en(ext_irq_en),
        .usb_en(usb_en), .irq_ack(irq_ack), .pin_sync(pin_sync), .irq_req(irq_req)
    );

    gpio_regs #(.DATA_ADDR(DATA_ADDR), .DIR_ADDR(DIR_ADDR), .DIR_MASK(DIR_MASK)) i_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .pin_sync(pin_sync), .bus_rdata(bus_rdata),
        .latch(latch), .dir(dir)
    );

    gpio_pad_mux #(.SPI_LSB(SPI_LSB), .USB_LSB(USB_LSB)) i_pad_mux (
        .latch(latch), .dir(dir), .spi_en(spi_en), .spi_out(spi_out), .spi_oe(spi_oe),
        .usb_en(usb_en), .usb_out(usb_out), .usb_oe(usb_oe),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_od(pin_od)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (pin_oe == '0 && !irq_req));
endmodule

// File: tb/test_gpio_mux_port.sv
module test_gpio_mux_port;
    localparam logic [7:0] A_DATA = 8'h01;
    localparam logic [7:0] A_DIR  = 8'h09;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] bus_addr = '0, bus_wdata = '0, bus_rdata, pin_in = '0;
    logic bus_wr = 1'b0;
    logic [7:0] pin_out, pin_oe, pin_od;
    logic spi_en = 1'b0, usb_en = 1'b0, ext_irq_en = 1'b0, irq_ack = 1'b0, irq_req;
    logic [3:0] spi_out = '0, spi_oe = '0;
    logic [1:0] usb_out = '0, usb_oe = '0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gpio_mux_port i_gpio_mux_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_od(pin_od), .spi_en(spi_en),
        .spi_out(spi_out), .spi_oe(spi_oe), .usb_en(usb_en), .usb_out(usb_out),
        .usb_oe(usb_oe), .ext_irq_en(ext_irq_en), .irq_ack(irq_ack), .irq_req(irq_req)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a; bus_wr = 1'b0;
        #1;
        d = bus_rdata;
    endtask

    // expected {out, oe, od} from R4, R6, R7, R8
    function automatic logic [23:0] exp_pads(input logic [7:0] dv, input logic [7:0] lv,
            input logic se, input logic [3:0] so, input logic [3:0] soe,
            input logic ue, input logic [1:0] uo, input logic [1:0] uoe);
        logic [7:0] o, e, d;
        o = lv; e = dv; d = '0;
        if (se) begin o[7:4] = so; e[7:4] = soe; end
        if (ue) begin o[3:2] = uo; e[3:2] = uoe; end
        else begin o[3:2] = 2'b00; e[3:2] = dv[3:2] & ~lv[3:2]; d[3:2] = 2'b11; end
        return {o, e, d};
    endfunction

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        logic [23:0] ex;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 oe", pin_oe, 8'h00);
        check("R1 irq", {7'b0, irq_req}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        bus_read(A_DIR, rd);  check("R1 dir", rd, 8'h00);
        bus_read(A_DATA, rd); check("R1 data", rd, 8'h00);
        bus_write(A_DIR, 8'hFC);
        bus_read(A_DATA, rd); check("R1 latch zero", rd, 8'h00);
        bus_write(A_DIR, 8'h00);

        // R2: direction register sweep
        for (int v = 0; v < 256; v++) begin
            bus_write(A_DIR, 8'(v));
            bus_read(A_DIR, rd);
            check("R2 dir readback", rd, 8'(v) & 8'hFC);
        end

        // R3..R8: sweep of direction, latch and ownership
        for (int d = 0; d < 64; d++) begin
            for (int l = 0; l < 8; l++) begin
                for (int m = 0; m < 4; m++) begin
                    logic [7:0] dv, lv, pv;
                    dv = 8'(d << 2);
                    lv = 8'((l * 73) ^ (d * 5));
                    pv = ~lv ^ 8'(m * 3);
                    spi_en = m[0]; usb_en = m[1];
                    spi_out = 4'(l + d); spi_oe = ~4'(d);
                    usb_out = 2'(l); usb_oe = 2'(d + l);
                    pin_in = pv;
                    bus_write(A_DATA, lv);
                    bus_write(A_DIR, dv);
                    ex = exp_pads(dv, lv, spi_en, spi_out, spi_oe, usb_en, usb_out, usb_oe);
                    check("R4 R6 R7 R8 pin_out", pin_out, ex[23:16]);
                    check("R4 R6 R7 R8 pin_oe", pin_oe, ex[15:8]);
                    check("R6 R7 R8 pin_od", pin_od, ex[7:0]);
                    bus_read(A_DATA, rd);
                    check("R3 R5 data read", rd, (dv & lv) | (~dv & pv));
                end
            end
        end

        // R4: latch preload does not enable an input pin
        spi_en = 1'b0; usb_en = 1'b1; usb_oe = 2'b00;
        bus_write(A_DIR, 8'h00);
        bus_write(A_DATA, 8'hFF);
        check("R4 preload no drive", pin_oe, 8'h00);
        bus_write(A_DIR, 8'hF0);
        check("R4 drive after dir", pin_oe, 8'hF0);
        check("R4 preloaded value", pin_out & 8'hF3, 8'hF3);

        // R5: pad change seen after exactly two edges
        bus_write(A_DIR, 8'h00);
        pin_in = 8'h00;
        repeat (3) @(negedge clk);
        pin_in = 8'hA5;
        @(negedge clk);
        bus_read(A_DATA, rd); check("R5 one edge old", rd, 8'h00);
        @(negedge clk);
        bus_read(A_DATA, rd); check("R5 two edges new", rd, 8'hA5);

        // R11: other addresses
        bus_write(A_DIR, 8'hFC);
        bus_write(A_DATA, 8'h55);
        for (int a = 0; a < 256; a++) begin
            if (8'(a) != A_DATA && 8'(a) != A_DIR) begin
                bus_write(8'(a), 8'hFF);
                bus_read(8'(a), rd);
                check("R11 unmapped read", rd, 8'h00);
            end
        end
        bus_read(A_DIR, rd); check("R11 dir kept", rd, 8'hFC);
        bus_read(A_DATA, rd); check("R11 latch kept", rd, (8'h55 & 8'hFC) | (8'hA5 & 8'h03));

        // R9: falling edge timing
        usb_en = 1'b0; ext_irq_en = 1'b1;
        pin_in = 8'h08;
        repeat (4) @(negedge clk);
        check("R10 rise no set", {7'b0, irq_req}, 8'h00);
        pin_in = 8'h00;
        repeat (2) @(negedge clk);
        check("R9 not yet", {7'b0, irq_req}, 8'h00);
        @(negedge clk);
        check("R9 set third edge", {7'b0, irq_req}, 8'h01);
        repeat (5) @(negedge clk);
        check("R10 held", {7'b0, irq_req}, 8'h01);
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
        check("R10 ack clears", {7'b0, irq_req}, 8'h00);

        // R9: set wins over simultaneous ack
        pin_in = 8'h08; repeat (4) @(negedge clk);
        pin_in = 8'h00; repeat (2) @(negedge clk);
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
        check("R9 set beats ack", {7'b0, irq_req}, 8'h01);

        // R10: disqualified by enable or by usb
        ext_irq_en = 1'b0; @(negedge clk);
        check("R10 enable off clears", {7'b0, irq_req}, 8'h00);
        pin_in = 8'h08; repeat (4) @(negedge clk);
        pin_in = 8'h00; repeat (4) @(negedge clk);
        check("R10 disabled fall", {7'b0, irq_req}, 8'h00);
        ext_irq_en = 1'b1; usb_en = 1'b1;
        pin_in = 8'h08; repeat (4) @(negedge clk);
        pin_in = 8'h00; repeat (4) @(negedge clk);
        check("R10 usb fall", {7'b0, irq_req}, 8'h00);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule